// File: doc/BRIEF.md
# Repeating DMA Channel Sequencer

This block is one channel of a DMA engine. Software programs a source address, a destination address, a word count and a reload address through a small register port. It then enables the channel with a control word. The control word also picks where transfer requests come from: an internal always-on request, an external request pin, or a peripheral request line. Each qualified request makes the channel present one word transfer on a valid/ready strobe that carries both addresses. After the handshake, the addresses step and the count drops by one. When the count reaches zero, the channel raises a one-cycle interrupt pulse if interrupts are enabled.

Without repeat, an exhausted channel sets a done flag and stays quiet until software clears that flag. With repeat, the channel restores the count to the value last written to the count register. It also loads the reload address into either the source or the destination, so a circular buffer is walked forever with no software help. A master enable pin and an emergency-stop flag gate every channel globally. The two single-address external codes drive an acknowledge pin while their strobe is presented. The transfer port follows valid/ready rules. Once `xfer_valid` rises, it stays high with both addresses unchanged until `xfer_ready` is seen high at a clock edge, and only that handshake advances the channel.

Top module: `dma_repeat_channel`

## Requirements
- R1: After reset, every register reads 0, `xfer_valid` is 0 and `irq` is 0.
- R2: With request code 4'b0100 (auto) in CTRL[11:8], the channel issues transfers while CTRL[0] (enable) = 1, `master_en` = 1, `nmi_flag` = 0, the done flag CTRL[12] = 0 and the count is non-zero. A new strobe starts one cycle after the previous handshake, so there is one transfer every two cycles when `xfer_ready` stays high.
- R3: At each handshake the count (register 2) drops by one. The source (register 0) advances by WORD_BYTES when CTRL[4] = 1 and otherwise stays fixed, and the destination (register 1) does the same under CTRL[5]. `xfer_src`/`xfer_dst` show the current addresses.
- R4: While `xfer_valid` = 1 and `xfer_ready` = 0, `xfer_valid`, `xfer_src` and `xfer_dst` hold their values.
- R5: With CTRL[2] (repeat) = 0, the handshake that takes the count to 0 sets the done flag CTRL[12]. No further strobe appears after that. A CTRL write with bit 12 = 0 clears the flag, and a write with bit 12 = 1 leaves it set.
- R6: `irq` is high for exactly the one cycle after the handshake that exhausts the count, and only if CTRL[1] = 1.
- R7: With CTRL[2] = 1, the exhausting handshake restores the count to the value last written to register 2. It also loads register 3 into the source when CTRL[3] = 0, or into the destination when CTRL[3] = 1, and transfers continue.
- R8: Codes 4'b0000 (dual address), 4'b0010 (memory to device) and 4'b0011 (device to memory) are external modes. In these modes, a strobe starts only when `dreq` is high at an edge while the channel is idle. On a channel whose CHANNEL_ID is not 0, writing one of these codes sets the address-error flag.
- R9: `dack` is high exactly while `xfer_valid` is high under codes 4'b0010 or 4'b0011. `xfer_to_dev` is 1 only for code 4'b0010.
- R10: With code 4'b1000, a strobe starts only when `periph_req` is high at an edge while the channel is idle.
- R11: A CTRL write with an unsupported code sets the address-error flag CTRL[13], and no strobe starts while it is set. A CTRL write with a supported code clears it.
- R12: While `master_en` = 0 or `nmi_flag` = 1, no new strobe starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 source, 1 destination, 2 count, 3 reload, 4 control |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Read data of the selected register |
| master_en | input | 1 | Global enable for all channels |
| nmi_flag | input | 1 | Global emergency stop |
| dreq | input | 1 | External transfer request |
| periph_req | input | 1 | Peripheral transfer request |
| xfer_valid | output | 1 | Word transfer strobe presented |
| xfer_ready | input | 1 | Bus accepts the presented transfer |
| xfer_src | output | AW | Source address of the transfer |
| xfer_dst | output | AW | Destination address of the transfer |
| xfer_to_dev | output | 1 | Single-address transfer toward the device |
| dack | output | 1 | Acknowledge to the external device |
| irq | output | 1 | End-of-count interrupt pulse |

## Verification
The bench builds the main instance with defaults: 32-bit addresses, a 16-bit count, 4-byte words and CHANNEL_ID 0. With these values every request code, both repeat reload targets and the acknowledge path can be exercised. A second instance uses CHANNEL_ID 1, which brings within reach the rejection of the external codes on a channel other than 0. The small counts used keep several full repeat laps, with their address reloads, inside a short run.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam logic [3:0] SEL_EXT_DUAL    = 4'h0;
  localparam logic [3:0] SEL_EXT_TODEV   = 4'h2;
  localparam logic [3:0] SEL_EXT_FROMDEV = 4'h3;
  localparam logic [3:0] SEL_AUTO        = 4'h4;
  localparam logic [3:0] SEL_PERIPH      = 4'h8;

  localparam logic [2:0] RA_SRC    = 3'd0;
  localparam logic [2:0] RA_DST    = 3'd1;
  localparam logic [2:0] RA_CNT    = 3'd2;
  localparam logic [2:0] RA_RELOAD = 3'd3;
  localparam logic [2:0] RA_CTRL   = 3'd4;

  localparam int CB_DONE = 12;

  typedef struct packed {
    logic [3:0] sel;
    logic [1:0] spare;
    logic       dinc;
    logic       sinc;
    logic       rld_dst;
    logic       rpt;
    logic       ie;
    logic       en;
  } ctrl_t;

  function automatic logic is_ext(input logic [3:0] s);
    return (s == SEL_EXT_DUAL) || (s == SEL_EXT_TODEV) || (s == SEL_EXT_FROMDEV);
  endfunction

  function automatic logic sel_ok(input logic [3:0] s, input logic ext_allowed);
    return (is_ext(s) && ext_allowed) || (s == SEL_AUTO) || (s == SEL_PERIPH);
  endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 4,
  parameter bit EXT_OK     = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          hs,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic          cnt_nz,
  output ctrl_t         ctrl_q,
  output logic          done_q,
  output logic          aerr_q,
  output logic          irq_q
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [CW-1:0] cnt_q, init_q;
  logic [AW-1:0] reload_q;
  logic          we_src, we_dst, we_cnt, we_rld, we_ctrl;
  logic          last, wrap, finish;
  ctrl_t         ctrl_w;

  assign we_src  = cfg_we && (cfg_addr == RA_SRC);
  assign we_dst  = cfg_we && (cfg_addr == RA_DST);
  assign we_cnt  = cfg_we && (cfg_addr == RA_CNT);
  assign we_rld  = cfg_we && (cfg_addr == RA_RELOAD);
  assign we_ctrl = cfg_we && (cfg_addr == RA_CTRL);
  assign ctrl_w  = ctrl_t'(cfg_wdata[CTRL_W-1:0]);

  assign last   = hs && (cnt_q == CW'(1));
  assign wrap   = last && ctrl_q.rpt;
  assign finish = last && !ctrl_q.rpt;
  assign cnt_nz = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      init_q   <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
      done_q   <= 1'b0;
      aerr_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      // software writes win over the sequencer's update of the same register
      if (we_src)                          src_q <= cfg_wdata;
      else if (wrap && !ctrl_q.rld_dst)    src_q <= reload_q;
      else if (hs && ctrl_q.sinc)          src_q <= src_q + STEP;

      if (we_dst)                          dst_q <= cfg_wdata;
      else if (wrap && ctrl_q.rld_dst)     dst_q <= reload_q;
      else if (hs && ctrl_q.dinc)          dst_q <= dst_q + STEP;

      if (we_cnt)                          cnt_q <= cfg_wdata[CW-1:0];
      else if (wrap)                       cnt_q <= init_q;
      else if (hs)                         cnt_q <= cnt_q - CW'(1);

      if (we_cnt)  init_q   <= cfg_wdata[CW-1:0];
      if (we_rld)  reload_q <= cfg_wdata;
      if (we_ctrl) begin
        ctrl_q <= ctrl_w;
        aerr_q <= !sel_ok(ctrl_w.sel, EXT_OK);
      end

      done_q <= finish || (done_q && !(we_ctrl && !cfg_wdata[CB_DONE]));
      irq_q  <= last && ctrl_q.ie;
    end
  end

  always_comb begin
    unique case (cfg_addr)
      RA_SRC:    cfg_rdata = src_q;
      RA_DST:    cfg_rdata = dst_q;
      RA_CNT:    cfg_rdata = AW'(cnt_q);
      RA_RELOAD: cfg_rdata = reload_q;
      RA_CTRL:   cfg_rdata = AW'({aerr_q, done_q, ctrl_q});
      default:   cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dmach_req_qual.sv
module dmach_req_qual
  import dmach_pkg::*;
#(
  parameter bit EXT_OK = 1'b1
) (
  input  logic  idle,
  input  ctrl_t ctrl,
  input  logic  master_en,
  input  logic  nmi_flag,
  input  logic  done,
  input  logic  aerr,
  input  logic  cnt_nz,
  input  logic  dreq,
  input  logic  periph_req,
  output logic  go,
  output logic  single,
  output logic  to_dev
);

  logic ext_req, int_req, enabled;

  generate
    if (EXT_OK) begin : g_ext
      assign ext_req = dreq && is_ext(ctrl.sel);
    end else begin : g_no_ext
      assign ext_req = dreq & 1'b0;
    end
  endgenerate

  assign int_req = (ctrl.sel == SEL_AUTO) || ((ctrl.sel == SEL_PERIPH) && periph_req);
  assign enabled = ctrl.en && master_en && !nmi_flag && !done && !aerr && cnt_nz;
  assign go      = idle && enabled && (int_req || ext_req);
  assign single  = (ctrl.sel == SEL_EXT_TODEV) || (ctrl.sel == SEL_EXT_FROMDEV);
  assign to_dev  = (ctrl.sel == SEL_EXT_TODEV);

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic ready,
  output logic busy,
  output logic hs
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            busy <= 1'b0;
    else if (busy && ready) busy <= 1'b0;
    else if (!busy && go)   busy <= 1'b1;
  end

  assign hs = busy && ready;

endmodule

// File: rtl/dma_repeat_channel.sv
module dma_repeat_channel
  import dmach_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 4,
  parameter int CHANNEL_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          master_en,
  input  logic          nmi_flag,
  input  logic          dreq,
  input  logic          periph_req,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [AW-1:0] xfer_src,
  output logic [AW-1:0] xfer_dst,
  output logic          xfer_to_dev,
  output logic          dack,
  output logic          irq
);

  localparam bit EXT_OK = (CHANNEL_ID == 0);

  ctrl_t ctrl_q;
  logic  done_q, aerr_q, cnt_nz, busy, hs, go, single;

  dmach_regs #(
    .AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES), .EXT_OK(EXT_OK)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hs(hs), .src_q(xfer_src), .dst_q(xfer_dst), .cnt_nz(cnt_nz),
    .ctrl_q(ctrl_q), .done_q(done_q), .aerr_q(aerr_q), .irq_q(irq)
  );

  dmach_req_qual #(.EXT_OK(EXT_OK)) qual_i (
    .idle(!busy), .ctrl(ctrl_q), .master_en(master_en), .nmi_flag(nmi_flag),
    .done(done_q), .aerr(aerr_q), .cnt_nz(cnt_nz), .dreq(dreq), .periph_req(periph_req),
    .go(go), .single(single), .to_dev(xfer_to_dev)
  );

  dmach_seq seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .ready(xfer_ready), .busy(busy), .hs(hs)
  );

  assign xfer_valid = busy;
  assign dack       = busy && single;

endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [AW-1:0] xfer_src,
  input logic [AW-1:0] xfer_dst,
  input logic          dack,
  input logic          irq,
  input logic          master_en,
  input logic          nmi_flag,
  input logic          aerr
);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_src) && $stable(xfer_dst)));

  assert_dack_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> xfer_valid);

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(xfer_valid && xfer_ready));

  assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_valid && (!master_en || nmi_flag)) |=> !xfer_valid);

  assert_aerr_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_valid && aerr) |=> !xfer_valid);

endmodule

bind dma_repeat_channel dmach_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .xfer_src(xfer_src), .xfer_dst(xfer_dst), .dack(dack), .irq(irq),
  .master_en(master_en), .nmi_flag(nmi_flag), .aerr(aerr_q)
);

// File: tb/dma_repeat_channel_tb_top.sv
`timescale 1ns/1ps
module dma_repeat_channel_tb_top;

  localparam int AW = 32;

  typedef struct packed {
    logic [15:0] ctrl;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cnt;
    logic [31:0] rel;
    logic [7:0]  exp_hs;   // 0: repeat entry, open-ended
    logic        exp_done;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{16'h0433, 32'h1000, 32'h2000, 16'd4, 32'h0,    8'd4, 1'b1},
    '{16'h0411, 32'h3000, 32'h4000, 16'd3, 32'h0,    8'd3, 1'b1},
    '{16'h0437, 32'h5000, 32'h6000, 16'd3, 32'h8000, 8'd0, 1'b0},
    '{16'h043F, 32'h5000, 32'h6000, 16'd2, 32'h9000, 8'd0, 1'b0},
    '{16'h0833, 32'hA000, 32'hB000, 16'd2, 32'h0,    8'd2, 1'b1},
    '{16'h0203, 32'hC000, 32'hD000, 16'd5, 32'h0,    8'd5, 1'b1},
    '{16'h0323, 32'hC000, 32'hD000, 16'd2, 32'h0,    8'd2, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_we1 = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata, cfg_rdata1;
  logic          master_en = 1'b0, nmi_flag = 1'b0, dreq = 1'b0, periph_req = 1'b0;
  logic          xfer_ready = 1'b1;
  logic          xfer_valid, xfer_to_dev, dack, irq;
  logic [AW-1:0] xfer_src, xfer_dst;
  logic          v1, td1, dack1, irq1;
  logic [AW-1:0] s1, d1;

  int checks = 0, errors = 0, n_hs = 0, n_irq = 0;
  bit finished = 1'b0, mon_en = 1'b0;
  logic [31:0] m_src, m_dst, m_rel;
  logic [15:0] m_cnt, m_init, m_ctrl;

  always #2 clk = ~clk;

  dma_repeat_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .master_en(master_en), .nmi_flag(nmi_flag), .dreq(dreq),
    .periph_req(periph_req), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_to_dev(xfer_to_dev), .dack(dack), .irq(irq)
  );

  dma_repeat_channel #(.CHANNEL_ID(1)) chan1_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we1), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata1), .master_en(1'b0), .nmi_flag(nmi_flag), .dreq(dreq),
    .periph_req(periph_req), .xfer_valid(v1), .xfer_ready(xfer_ready),
    .xfer_src(s1), .xfer_dst(d1), .xfer_to_dev(td1), .dack(dack1), .irq(irq1)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // handshake monitor with an address/count model taken from R3, R7, R9
  always @(negedge clk) begin
    if (mon_en) begin
      if (xfer_valid && xfer_ready) begin
        chk(xfer_src == m_src, "R3 src", xfer_src, m_src);
        chk(xfer_dst == m_dst, "R3 dst", xfer_dst, m_dst);
        chk(dack == (m_ctrl[11:8] == 4'h2 || m_ctrl[11:8] == 4'h3), "R9 dack", 32'(dack), 32'(!dack));
        n_hs++;
        m_cnt = m_cnt - 16'd1;
        if (m_ctrl[4]) m_src = m_src + 32'd4;
        if (m_ctrl[5]) m_dst = m_dst + 32'd4;
        if (m_cnt == 16'd0 && m_ctrl[2]) begin
          m_cnt = m_init;
          if (m_ctrl[3]) m_dst = m_rel; else m_src = m_rel;
        end
      end
      if (irq) n_irq++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wr1(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we1 = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we1 = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    cfg_addr = a; #0.5;
    v = cfg_rdata;
  endtask

  task automatic setup(input logic [15:0] c, input logic [31:0] s, input logic [31:0] d,
                       input logic [15:0] n, input logic [31:0] r);
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, 32'(n)); wr(3'd3, r);
    m_src = s; m_dst = d; m_cnt = n; m_init = n; m_rel = r; m_ctrl = c;
    n_hs = 0; n_irq = 0;
    wr(3'd4, 32'(c));
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 32'(finished), 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    mon_en = 1'b1;

    // R1: reset state
    rd(3'd4, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'd0, v); chk(v == 0, "R1 src", v, 0);
    rd(3'd2, v); chk(v == 0, "R1 cnt", v, 0);
    chk(!xfer_valid && !irq, "R1 outputs", {30'd0, xfer_valid, irq}, 0);

    // table walk: R2 R3 R5 R6 R7 R8 R9 R10
    dreq = 1'b1; periph_req = 1'b1;
    for (int i = 0; i < 7; i++) begin
      master_en = 1'b0;
      setup(VEC[i].ctrl, VEC[i].src, VEC[i].dst, VEC[i].cnt, VEC[i].rel);
      master_en = 1'b1;
      cycles(40);
      master_en = 1'b0;
      cycles(4);
      if (VEC[i].exp_hs != 0) begin
        chk(n_hs == int'(VEC[i].exp_hs), "R2 transfer count", n_hs, VEC[i].exp_hs);
        chk(n_irq == (VEC[i].ctrl[1] ? 1 : 0), "R6 irq count", n_irq, VEC[i].ctrl[1]);
      end else begin
        chk(n_hs > 2 * int'(VEC[i].cnt), "R7 keeps running", n_hs, 2 * VEC[i].cnt + 1);
        chk(n_irq == n_hs / int'(VEC[i].cnt), "R7 irq per lap", n_irq, n_hs / VEC[i].cnt);
      end
      rd(3'd0, v); chk(v == m_src, "R3 src readback", v, m_src);
      rd(3'd1, v); chk(v == m_dst, "R3 dst readback", v, m_dst);
      rd(3'd2, v); chk(v == 32'(m_cnt), "R7 cnt readback", v, 32'(m_cnt));
      rd(3'd4, v); chk(v[12] == VEC[i].exp_done, "R5 done flag", 32'(v[12]), 32'(VEC[i].exp_done));
    end
    dreq = 1'b0; periph_req = 1'b0;

    // R11: unsupported code
    setup(16'h0103, 32'h100, 32'h200, 16'd3, 32'h0);
    master_en = 1'b1;
    cycles(20);
    chk(n_hs == 0, "R11 no transfer", n_hs, 0);
    rd(3'd4, v); chk(v[13] == 1'b1, "R11 error flag", 32'(v[13]), 1);
    wr(3'd4, 32'h0000);
    rd(3'd4, v); chk(v[13] == 1'b0, "R11 error cleared", 32'(v[13]), 0);

    // R12 then R2: emergency stop gates auto mode
    master_en = 1'b0;
    setup(16'h0403, 32'h100, 32'h200, 16'd3, 32'h0);
    nmi_flag = 1'b1; master_en = 1'b1;
    cycles(20);
    chk(n_hs == 0, "R12 nmi blocks", n_hs, 0);
    nmi_flag = 1'b0;
    cycles(20);
    chk(n_hs == 3, "R2 resumes", n_hs, 3);

    // R8: external dual mode needs dreq
    setup(16'h0003, 32'h100, 32'h200, 16'd4, 32'h0);
    cycles(10);
    chk(n_hs == 0, "R8 idle without dreq", n_hs, 0);
    dreq = 1'b1; cycles(1); dreq = 1'b0;
    cycles(10);
    chk(n_hs == 1, "R8 one per request", n_hs, 1);
    chk(!xfer_to_dev, "R9 to_dev dual", 32'(xfer_to_dev), 0);

    // R10: peripheral mode needs periph_req
    setup(16'h0803, 32'h100, 32'h200, 16'd2, 32'h0);
    cycles(10);
    chk(n_hs == 0, "R10 idle without request", n_hs, 0);
    periph_req = 1'b1; cycles(10); periph_req = 1'b0;
    chk(n_hs == 2, "R10 transfers", n_hs, 2);

    // R4: back-pressure
    xfer_ready = 1'b0;
    setup(16'h0413, 32'h100, 32'h200, 16'd4, 32'h0);
    cycles(8);
    chk(xfer_valid == 1'b1, "R4 valid held", 32'(xfer_valid), 1);
    chk(xfer_src == 32'h100, "R4 src held", xfer_src, 32'h100);
    chk(n_hs == 0, "R4 no handshake", n_hs, 0);
    chk(dack == 1'b0, "R9 no dack in auto", 32'(dack), 0);
    xfer_ready = 1'b1;
    cycles(24);
    chk(n_hs == 4, "R5 stops after count", n_hs, 4);

    // R5: done flag clear semantics
    wr(3'd4, 32'h1413);
    rd(3'd4, v); chk(v[12] == 1'b1, "R5 write 1 keeps", 32'(v[12]), 1);
    wr(3'd4, 32'h0413);
    rd(3'd4, v); chk(v[12] == 1'b0, "R5 write 0 clears", 32'(v[12]), 0);

    // R8: channel other than 0 rejects external codes
    wr1(3'd4, 32'h0203);
    cfg_addr = 3'd4; #0.5;
    chk(cfg_rdata1[13] == 1'b1, "R8 ext on channel 1", 32'(cfg_rdata1[13]), 1);
    wr1(3'd4, 32'h0403);
    cfg_addr = 3'd4; #0.5;
    chk(cfg_rdata1[13] == 1'b0, "R8 auto on channel 1", 32'(cfg_rdata1[13]), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule